// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block is the host side of a passive serial configuration link. A one-cycle start pulse makes it pull the active-low configuration request low for a set number of system clocks and then release it. It then waits for the target's ready flag to come high. After that it reads the bitstream one byte at a time from a byte-wide memory port and shifts each byte out on a single data line, least significant bit first. The data line is set up while the generated serial clock is low, so the target samples it on the clock's rising edge.

When the target reports that configuration is complete, the loader gives exactly two further serial-clock falling edges and parks the clock low. It then waits for the initialization-done flag to rise, which marks the target's entry into user mode, and reports completion. Several faults end the load with an error flag and return the loader to idle: the ready flag dropping during clocking, the memory running out of bytes, or any of the wait phases running past its cycle budget. All three target flags pass through two-flop synchronizers before they are used.

Top module: `psh_loader`

## Requirements
- R1: A start pulse while idle drives `cfg_req_n_o` low for exactly REQ_LOW system clocks (default 4) and then returns it high. `busy_o` is 1 while the load runs.
- R2: No rising edge appears on `dclk_o` until the synchronized `stat_i` has been seen high after the request is released.
- R3: Bytes are read from addresses 0, 1, 2 and onward in that order, and each byte is sent bit 0 first. The bytes 02 1B EE 01 FA give the serial stream 0100_0000 1101_1000 0111_0111 1000_0000 0101_1111.
- R4: `data_o` changes only while `dclk_o` is low. It stays constant for as long as `dclk_o` is high, and a memory read is made only while `dclk_o` is low.
- R5: The high and low phases of `dclk_o` each last HALF system clocks (default 2).
- R6: Once `cdone_i` has risen, `dclk_o` gives exactly two more falling edges and then stays low.
- R7: A low-to-high change of `idone_i` after the extra clocks sets `done_o` to 1 and returns `busy_o` to 0. `done_o` is not set before that change.
- R8: If `stat_i` goes low while the serial clock is running, `err_o` is set, `dclk_o` and `data_o` go low, and the loader returns to idle.
- R9: If NBYTES bytes have been sent and `cdone_i` has not been seen, `err_o` is set after exactly NBYTES*8 rising edges of `dclk_o`.
- R10: Waiting longer than STAT_TO clocks for `stat_i`, or longer than IDONE_TO clocks for `idone_i`, sets `err_o` and ends the load. Clocking longer than CDONE_TO clocks also sets `err_o`.
- R11: While idle, `dclk_o` is 0, `data_o` is 0, `cfg_req_n_o` is 1 and `mem_req_o` is 0.
- R12: `done_o` and `err_o` are never 1 together. Each keeps its value until the next accepted start, and that start clears both.
- R13: A start pulse while `busy_o` is 1 is ignored, and the running load continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| mem_addr_o | output | AW | Byte address of the next bitstream byte |
| mem_req_o | output | 1 | Read request, held until `mem_valid_i` |
| mem_data_i | input | 8 | Byte returned by the memory |
| mem_valid_i | input | 1 | `mem_data_i` is valid for the pending request |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| dclk_o | output | 1 | Serial configuration clock |
| data_o | output | 1 | Serial configuration data |
| stat_i | input | 1 | Target ready/status flag (asynchronous) |
| cdone_i | input | 1 | Target configuration-done flag (asynchronous) |
| idone_i | input | 1 | Target initialization-done flag (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load reached user mode |
| err_o | output | 1 | Last load ended in a fault |

## Verification
The bench raises configuration-done during a low phase of the serial clock and counts falling edges from that point. A loader that stops clocking at once would show zero edges, and one that keeps clocking would show more than two. The captured serial bits are compared with the stream given in R3, so a loader that sent bytes MSB first or read the memory out of order would produce a different stream. The bench also drops the ready flag in the middle of a byte, lets a short bitstream run out of bytes, and withholds the flags for the status wait and the initialization wait. A loader that kept clocking, sent bits past the end of memory or hung in a wait state would leave the error flag clear. A start pulse given in the middle of a load must leave the stream intact, so a loader that restarted on it would send a corrupted stream.

// File: rtl/psh_pkg.sv
package psh_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WSTAT,
        S_FETCH,
        S_LOW,
        S_HIGH,
        S_WINIT
    } psh_state_e;
endpackage

// File: rtl/psh_sync.sv
module psh_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/psh_budget.sv
module psh_budget #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/psh_loader.sv
module psh_loader
    import psh_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NBYTES   = 1024,
    parameter int REQ_LOW  = 4,
    parameter int HALF     = 2,
    parameter int TW       = 20,
    parameter int STAT_TO  = 1000,
    parameter int CDONE_TO = 1000000,
    parameter int IDONE_TO = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_req_o,
    input  logic [7:0]    mem_data_i,
    input  logic          mem_valid_i,
    output logic          cfg_req_n_o,
    output logic          dclk_o,
    output logic          data_o,
    input  logic          stat_i,
    input  logic          cdone_i,
    input  logic          idone_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int PMAX = (HALF > REQ_LOW) ? HALF : REQ_LOW;
    localparam int PW   = $clog2(PMAX + 1);
    localparam int BCW  = $clog2(NBYTES + 1);
    localparam logic [PW-1:0]  PH_END = PW'(HALF - 1);
    localparam logic [PW-1:0]  RQ_END = PW'(REQ_LOW - 1);
    localparam logic [BCW-1:0] BC_END = BCW'(NBYTES);

    typedef struct packed {
        psh_state_e     st;
        logic [PW-1:0]  ph;
        logic [BCW-1:0] bcnt;
        logic [7:0]     sh;
        logic [2:0]     bi;
        logic           seen;
        logic           tail;
        logic           dclk;
        logic           dat;
        logic           req_n;
        logic           mreq;
        logic           done;
        logic           err;
        logic           idp;
    } regs_t;

    regs_t r_q, r_d;

    logic [2:0]    flags_s;
    logic          stat_s, cdone_s, idone_s;
    logic          wd_clr, wd_exp, fail, seen_now;
    logic [TW-1:0] wd_lim;

    psh_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({idone_i, cdone_i, stat_i}),
        .sync_o  (flags_s)
    );
    assign stat_s  = flags_s[0];
    assign cdone_s = flags_s[1];
    assign idone_s = flags_s[2];

    psh_budget #(.W(TW)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wd_clr),
        .limit   (wd_lim),
        .expired (wd_exp)
    );

    always_comb begin
        case (r_q.st)
            S_WSTAT: wd_lim = TW'(STAT_TO);
            S_WINIT: wd_lim = TW'(IDONE_TO);
            default: wd_lim = TW'(CDONE_TO);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        wd_clr   = 1'b0;
        fail     = 1'b0;
        seen_now = r_q.seen | cdone_s;
        r_d.idp  = idone_s;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st    = S_REQ;
                    r_d.ph    = '0;
                    r_d.req_n = 1'b0;
                    r_d.done  = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.bcnt  = '0;
                    r_d.seen  = 1'b0;
                    r_d.tail  = 1'b0;
                end
            end
            S_REQ: begin
                if (r_q.ph == RQ_END) begin
                    r_d.req_n = 1'b1;
                    r_d.st    = S_WSTAT;
                    wd_clr    = 1'b1;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            S_WSTAT: begin
                if (stat_s) begin
                    r_d.st = S_FETCH;
                    wd_clr = 1'b1;
                end else if (wd_exp) begin
                    fail = 1'b1;
                end
            end
            S_FETCH, S_LOW, S_HIGH: begin
                r_d.seen = seen_now;
                if (!stat_s || wd_exp) begin
                    fail = 1'b1;
                end else if (r_q.st == S_FETCH) begin
                    if (seen_now) begin
                        r_d.mreq = 1'b0;
                        r_d.dat  = 1'b0;
                        r_d.ph   = '0;
                        r_d.st   = S_LOW;
                    end else if (r_q.bcnt == BC_END) begin
                        fail = 1'b1;
                    end else if (r_q.mreq && mem_valid_i) begin
                        r_d.mreq = 1'b0;
                        r_d.sh   = mem_data_i;
                        r_d.dat  = mem_data_i[0];
                        r_d.bi   = 3'd0;
                        r_d.bcnt = r_q.bcnt + 1'b1;
                        r_d.ph   = '0;
                        r_d.st   = S_LOW;
                    end else begin
                        r_d.mreq = 1'b1;
                    end
                end else if (r_q.ph != PH_END) begin
                    r_d.ph = r_q.ph + 1'b1;
                end else if (r_q.st == S_LOW) begin
                    r_d.ph   = '0;
                    r_d.dclk = 1'b1;
                    r_d.st   = S_HIGH;
                end else begin
                    r_d.ph   = '0;
                    r_d.dclk = 1'b0;
                    if (seen_now) begin
                        r_d.dat = 1'b0;
                        if (r_q.tail) begin
                            r_d.st = S_WINIT;
                            wd_clr = 1'b1;
                        end else begin
                            r_d.tail = 1'b1;
                            r_d.st   = S_LOW;
                        end
                    end else if (r_q.bi == 3'd7) begin
                        r_d.st = S_FETCH;
                    end else begin
                        r_d.bi  = r_q.bi + 3'd1;
                        r_d.dat = r_q.sh[r_q.bi + 3'd1];
                        r_d.st  = S_LOW;
                    end
                end
            end
            S_WINIT: begin
                if (idone_s && !r_q.idp) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (wd_exp) begin
                    fail = 1'b1;
                end
            end
            default: fail = 1'b1;
        endcase
        if (fail) begin
            r_d.st    = S_IDLE;
            r_d.err   = 1'b1;
            r_d.done  = 1'b0;
            r_d.dclk  = 1'b0;
            r_d.dat   = 1'b0;
            r_d.mreq  = 1'b0;
            r_d.req_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.req_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = AW'(r_q.bcnt);
    assign mem_req_o   = r_q.mreq;
    assign cfg_req_n_o = r_q.req_n;
    assign dclk_o      = r_q.dclk;
    assign data_o      = r_q.dat;
    assign busy_o      = (r_q.st != S_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
endmodule

// File: rtl/psh_loader_chk.sv
module psh_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic dclk_o,
    input logic data_o,
    input logic cfg_req_n_o,
    input logic mem_req_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic stat_s
);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dclk_o && !data_o && cfg_req_n_o && !mem_req_o));

    a_r1_request_inside_load: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n_o |-> busy_o);

    a_r2_clock_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $past(stat_s));

    a_r4_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data_o));

    a_r4_fetch_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !dclk_o);

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r7_done_ends_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o);
endmodule

bind psh_loader psh_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dclk_o      (dclk_o),
    .data_o      (data_o),
    .cfg_req_n_o (cfg_req_n_o),
    .mem_req_o   (mem_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .stat_s      (stat_s)
);

// File: tb/sim_psh_loader.sv
module sim_psh_loader;
    localparam int CLK_PERIOD = 10;
    localparam int AW       = 8;
    localparam int NB       = 8;
    localparam int HALF     = 2;
    localparam int REQ_LOW  = 4;
    localparam int STAT_TO  = 40;
    localparam int IDONE_TO = 60;
    localparam logic [39:0] STREAM = 40'b0100000011011000011101111000000001011111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_req;
    logic [7:0]    mem_data = 8'h00;
    logic          mem_valid = 1'b0;
    logic          cfg_req_n, dclk, data;
    logic          stat = 1'b0, cdone = 1'b0, idone = 1'b0;
    logic          busy, done, err;

    int nchk = 0;
    int nfail = 0;
    int rises = 0;
    int falls = 0;
    int rises_nostat = 0;
    int ncap = 0;
    int bad_chg = 0;
    logic capb [0:127];
    logic [7:0] rom [0:NB-1];
    logic prev_dclk = 1'b0;
    logic prev_data = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psh_loader #(
        .AW(AW), .NBYTES(NB), .REQ_LOW(REQ_LOW), .HALF(HALF), .TW(20),
        .STAT_TO(STAT_TO), .CDONE_TO(100000), .IDONE_TO(IDONE_TO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .mem_addr_o(mem_addr), .mem_req_o(mem_req),
        .mem_data_i(mem_data), .mem_valid_i(mem_valid),
        .cfg_req_n_o(cfg_req_n), .dclk_o(dclk), .data_o(data),
        .stat_i(stat), .cdone_i(cdone), .idone_i(idone),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    always @(posedge clk) begin
        mem_valid <= mem_req && !mem_valid;
        mem_data  <= rom[mem_addr[2:0]];
    end

    always @(posedge dclk) begin
        if (!stat) rises_nostat++;
        if (ncap < 128) capb[ncap] = data;
        ncap++;
        rises++;
    end

    always @(negedge dclk) falls++;

    always @(negedge clk) begin
        if (dclk && prev_dclk && (data != prev_data)) bad_chg++;
        prev_dclk = dclk;
        prev_data = data;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic prep();
        stat = 1'b0; cdone = 1'b0; idone = 1'b0;
        cyc(4);
        rises = 0; falls = 0; rises_nostat = 0; ncap = 0; bad_chg = 0;
    endtask

    task automatic wait_req_high();
        for (int i = 0; i < 20 && !cfg_req_n; i++) @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        for (int i = 0; i < 4000 && ncap < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        chk("R11 dclk in reset", int'(dclk), 0);
        chk("R11 data in reset", int'(data), 0);
        chk("R11 request in reset", int'(cfg_req_n), 1);
        chk("R11 mem_req in reset", int'(mem_req), 0);
        chk("R12 flags in reset", int'({busy, done, err}), 0);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_full_load();
        int lowc = 0;
        int f0 = 0;
        int hic = 0;
        int mism = 0;
        prep();
        pulse_start();
        for (int i = 0; i < 10 && cfg_req_n; i++) @(negedge clk);
        while (!cfg_req_n && lowc < 50) begin
            lowc++;
            @(negedge clk);
        end
        chk("R1 request low cycles", lowc, REQ_LOW);
        chk("R1 busy during load", int'(busy), 1);
        cyc(6);
        chk("R2 no clock before ready", rises, 0);
        stat = 1'b1;
        wait_bits(10);
        pulse_start();
        @(posedge dclk);
        @(negedge clk);
        while (dclk && hic < 20) begin
            hic++;
            @(negedge clk);
        end
        chk("R5 high phase cycles", hic, HALF);
        hic = 0;
        while (!dclk && hic < 20) begin
            hic++;
            @(negedge clk);
        end
        chk("R5 low phase cycles", hic, HALF);
        wait_bits(40);
        @(negedge dclk);
        @(negedge clk);
        cdone = 1'b1;
        f0 = falls;
        cyc(40);
        chk("R6 falling edges after cdone", falls - f0, 2);
        chk("R6 dclk parked low", int'(dclk), 0);
        chk("R7 no done before idone", int'(done), 0);
        chk("R13 still busy after mid-load start", int'(busy), 1);
        for (int i = 0; i < 40; i++) if (capb[i] !== STREAM[39-i]) mism++;
        chk("R3 stream mismatches", mism, 0);
        chk("R4 data changes while dclk high", bad_chg, 0);
        idone = 1'b1;
        cyc(6);
        chk("R7 done after idone rise", int'(done), 1);
        chk("R7 busy cleared", int'(busy), 0);
        chk("R12 no error on good load", int'(err), 0);
        cyc(5);
        chk("R12 done held", int'(done), 1);
        chk("R11 dclk idle", int'(dclk), 0);
    endtask

    task automatic t_status_drop();
        prep();
        pulse_start();
        cyc(1);
        chk("R12 start clears done", int'(done), 0);
        wait_req_high();
        stat = 1'b1;
        wait_bits(11);
        stat = 1'b0;
        cyc(8);
        chk("R8 error on status drop", int'(err), 1);
        chk("R8 idle after drop", int'(busy), 0);
        chk("R8 dclk low after drop", int'(dclk), 0);
        chk("R11 data low after drop", int'(data), 0);
        chk("R12 done clear on error", int'(done), 0);
    endtask

    task automatic t_exhaust();
        prep();
        pulse_start();
        cyc(1);
        chk("R12 start clears error", int'(err), 0);
        wait_req_high();
        stat = 1'b1;
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        chk("R9 rising edges before exhaustion", rises, NB * 8);
        chk("R9 error on exhaustion", int'(err), 1);
        chk("R9 idle after exhaustion", int'(busy), 0);
    endtask

    task automatic t_idone_timeout();
        prep();
        pulse_start();
        wait_req_high();
        stat = 1'b1;
        wait_bits(16);
        @(negedge dclk);
        @(negedge clk);
        cdone = 1'b1;
        cyc(30);
        chk("R10 no error inside idone budget", int'(err), 0);
        chk("R10 still waiting", int'(busy), 1);
        cyc(IDONE_TO);
        chk("R10 error after idone budget", int'(err), 1);
        chk("R10 idle after idone budget", int'(busy), 0);
    endtask

    task automatic t_stat_timeout();
        prep();
        pulse_start();
        cyc(REQ_LOW + 10);
        chk("R10 waiting for status", int'(busy), 1);
        cyc(STAT_TO + 10);
        chk("R10 error after status budget", int'(err), 1);
        chk("R2 no clock without status", rises, 0);
    endtask

    task automatic t_busy_start();
        prep();
        pulse_start();
        wait_req_high();
        stat = 1'b1;
        wait_bits(3);
        pulse_start();
        cyc(2);
        chk("R13 request stays released", int'(cfg_req_n), 1);
        wait_bits(24);
        begin
            int mism = 0;
            for (int i = 0; i < 24; i++) if (capb[i] !== STREAM[39-i]) mism++;
            chk("R13 stream intact after busy start", mism, 0);
        end
        stat = 1'b0;
        cyc(8);
    endtask

    initial begin
        rom[0] = 8'h02; rom[1] = 8'h1B; rom[2] = 8'hEE; rom[3] = 8'h01;
        rom[4] = 8'hFA; rom[5] = 8'h55; rom[6] = 8'hAA; rom[7] = 8'h3C;
        t_reset();
        t_full_load();
        t_status_drop();
        t_exhaust();
        t_idone_timeout();
        t_stat_timeout();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule